// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sits between a 32-bit register bus and an on-chip flash array. It decides when the array may be written. Software first opens the controller with a two-word key sequence. It then selects an action through mode bits in a control register and launches the action with a start bit, or, for half-word programming, with a 16-bit write into the flash window. While the array works, a busy flag stays high. A finished action raises an end-of-operation flag. A refused action raises one of two error flags instead and leaves the array unchanged. All three flags are cleared by writing 1 to them.

A write-protection register holds one bit per group of four pages, and a cleared bit guards its group. This register can only be changed after a second key sequence on a separate option key register, with option-write enable set. Changes can only clear bits. An option erase sets all of the bits again. The flash array is modelled inside the block: every half-word reads 0xFFFF after reset, and each action takes a fixed number of cycles to complete.

Register word offsets on `reg_addr` and `reg_raddr`:

| Offset | Register |
|---|---|
| 0 | key |
| 1 | option key |
| 2 | status |
| 3 | control |
| 4 | address (byte address) |
| 5 | write protection |

Reads of any other offset, including both key offsets, return 0.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After a synchronous reset, the registers read as follows: status 0, control 0x80 (lock bit 7 set), address 0, write protection 0xF. Every array half-word reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to key offset 0 unlocks the controller, and control bit 7 then reads 0. While the controller is locked, control writes are ignored.
- R3: A key write with a wrong value, or the second key written first, keeps the controller locked until the next reset, even if a correct sequence follows.
- R4: Writing a control value with bit 7 set relocks the controller and clears all mode bits. Flash writes and control writes are then ignored until a fresh key sequence is written.
- R5: With control bit 0 set and the controller unlocked, a write to a blank half-word through the flash window starts a program. Status bit 0 (busy) is high for PROG_CYC cycles from the next cycle on. The array takes the data, and status bit 5 (end of operation) sets, on the edge where busy falls.
- R6: A program aimed at a half-word that does not read 0xFFFF sets status bit 2, leaves the array unchanged and does not raise busy.
- R7: Writing control bit 1 (page erase), loading a byte address into the address register, and then writing bits 1 and 6 (start) together erases the addressed page to 0xFFFF after ERASE_CYC busy cycles. Other pages are left unchanged.
- R8: A control write with bits 2 and 6 set erases the whole array after MASS_CYC busy cycles. Bit 2 takes precedence over bit 1.
- R9: Write-protection bit g guards pages 4g to 4g+3, and a value of 0 protects the group. A program or page erase into a protected group, or a mass erase while any bit is 0, sets status bit 4 and leaves the array unchanged.
- R10: Status bits 2, 4 and 5 clear when 1 is written to them. Writing 0 to them has no effect.
- R11: The write-protection register accepts a write only after 0x45670123 and then 0xCDEF89AB have been written to option key offset 1 while the controller is unlocked, and only with control bits 4 and 9 set. The written value is ANDed into the current value.
- R12: With the option keys open, a control write with bits 5, 9 and 6 set (and bits 1 and 2 clear) sets every write-protection bit and sets status bit 5.
- R13: While busy is high, writes to the control and address registers are ignored, and so are flash-window writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read word offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_wr | input | 1 | Flash window 16-bit write strobe |
| fl_widx | input | 6 | Half-word index of the flash write |
| fl_wdata | input | 16 | Flash write data |
| fl_ridx | input | 6 | Half-word index of the flash read |
| fl_rdata | output | 16 | Flash read data (combinational) |

## Verification
A register write sampled at a clock edge is visible on the read port straight after that edge. A refused action shows its error bit at the same point, without busy. An accepted action raises busy on the edge that samples it. Busy then falls PROG_CYC, ERASE_CYC or MASS_CYC edges later, and the array update and end-of-operation flag appear on that same edge. The bench drives inputs 2 ns after each rising edge and compares both read ports with its behavioural model at every falling edge. Its directed reads are placed at the exact edge counts given above, so a single cycle too early or too late is caught.

// File: rtl/flash_pe_pkg.sv
// Package flash_pe_pkg
// Shared register offsets, bit positions, key values and the enumerations
// used by the flash program/erase controller.
package flash_pe_pkg;

    localparam logic [2:0] OFS_KEY   = 3'd0;
    localparam logic [2:0] OFS_OKEY  = 3'd1;
    localparam logic [2:0] OFS_STAT  = 3'd2;
    localparam logic [2:0] OFS_CTRL  = 3'd3;
    localparam logic [2:0] OFS_ADDR  = 3'd4;
    localparam logic [2:0] OFS_WPROT = 3'd5;

    localparam int C_PG   = 0;
    localparam int C_PER  = 1;
    localparam int C_MER  = 2;
    localparam int C_OPG  = 4;
    localparam int C_OER  = 5;
    localparam int C_STRT = 6;
    localparam int C_LOCK = 7;
    localparam int C_OWE  = 9;

    localparam int S_BSY = 0;
    localparam int S_PGE = 2;
    localparam int S_WPE = 4;
    localparam int S_EOP = 5;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;
    localparam logic [15:0] BLANK_HW   = 16'hFFFF;

    // Control bits that are held in the register (start and lock are actions).
    localparam logic [9:0] CTRL_KEEP = 10'b10_0011_0111;

    typedef enum logic [1:0] {KS_WAIT_A, KS_WAIT_B, KS_OPEN, KS_BARRED} key_state_e;
    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_PAGE, OP_MASS} op_e;

endpackage

// File: rtl/flash_pe_keyseq.sv
// Module flash_pe_keyseq
// Tracks a two-word unlock sequence for one key register.
// Assumes key_wr is a single-cycle strobe. Writes are only counted while
// enable is high. A wrong word bars the sequence until reset. relock returns
// an open or half-open sequence to its start state.
module flash_pe_keyseq
    import flash_pe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        enable,
    input  logic        relock,
    output logic        open
);

    key_state_e st;

    // Step through the key words, bar on any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KS_WAIT_A;
        end else if (relock && st != KS_BARRED) begin
            st <= KS_WAIT_A;
        end else if (key_wr && enable) begin
            case (st)
                KS_WAIT_A: st <= (key_data == KEY_FIRST)  ? KS_WAIT_B : KS_BARRED;
                KS_WAIT_B: st <= (key_data == KEY_SECOND) ? KS_OPEN   : KS_BARRED;
                default:   st <= st;
            endcase
        end
    end

    assign open = (st == KS_OPEN);

    assert_barred_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st == KS_BARRED |=> st == KS_BARRED);

    assert_open_after_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(key_wr && key_data == KEY_SECOND));

endmodule

// File: rtl/flash_pe_array.sv
// Module flash_pe_array
// Behavioural flash array with a timed busy handshake. An accepted start
// loads a cycle counter. The write or erase lands on the edge where the
// counter expires, and finish is high in the cycle before that edge.
// Assumes start_op is OP_NONE whenever busy is high.
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int PAGE_HW   = 4,
    parameter int PROG_CYC  = 3,
    parameter int ERASE_CYC = 6,
    parameter int MASS_CYC  = 10,
    localparam int AW   = $clog2(WORDS),
    localparam int PB   = $clog2(PAGE_HW),
    localparam int MAXC = (MASS_CYC > ERASE_CYC) ?
                          ((MASS_CYC > PROG_CYC) ? MASS_CYC : PROG_CYC) :
                          ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC),
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           start_op,
    input  logic [AW-1:0] start_idx,
    input  logic [15:0]   start_data,
    output logic          busy,
    output logic          finish,
    input  logic [AW-1:0] rd_idx,
    output logic [15:0]   rd_data,
    input  logic [AW-1:0] chk_idx,
    output logic [15:0]   chk_data
);

    logic [15:0]   mem [WORDS];
    op_e           op_q;
    logic [AW-1:0] idx_q;
    logic [15:0]   data_q;
    logic [CW-1:0] cnt;

    assign finish = busy && (cnt == CW'(1));

    // Latch an action and count its duration down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_NONE;
            idx_q  <= '0;
            data_q <= '0;
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
            busy <= !finish;
        end else if (start_op != OP_NONE) begin
            busy   <= 1'b1;
            op_q   <= start_op;
            idx_q  <= start_idx;
            data_q <= start_data;
            case (start_op)
                OP_PROG: cnt <= CW'(PROG_CYC);
                OP_PAGE: cnt <= CW'(ERASE_CYC);
                default: cnt <= CW'(MASS_CYC);
            endcase
        end
    end

    // Apply the finished action to the cells.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= BLANK_HW;
        end else if (finish) begin
            case (op_q)
                OP_PROG: mem[idx_q] <= mem[idx_q] & data_q;
                OP_PAGE: begin
                    for (int i = 0; i < WORDS; i++)
                        if (AW'(i >> PB) == AW'(idx_q >> PB)) mem[i] <= BLANK_HW;
                end
                OP_MASS: begin
                    for (int i = 0; i < WORDS; i++) mem[i] <= BLANK_HW;
                end
                default: ;
            endcase
        end
    end

    assign rd_data  = mem[rd_idx];
    assign chk_data = mem[chk_idx];

    assert_start_raises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_op != OP_NONE && !busy) |=> busy);

endmodule

// File: rtl/flash_pe_ctrl.sv
// Module flash_pe_ctrl (top)
// Register front end of the flash program/erase controller: key and option
// key sequencing, the control, address and write-protection registers, the
// write-one-to-clear status flags, and launching actions into the array.
// Assumes single-cycle write strobes. Reads are combinational.
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int PAGE_HW     = 4,
    parameter int GROUP_PAGES = 4,
    parameter int PROG_CYC    = 3,
    parameter int ERASE_CYC   = 6,
    parameter int MASS_CYC    = 10,
    localparam int WORDS  = PAGES * PAGE_HW,
    localparam int AW     = $clog2(WORDS),
    localparam int BAW    = AW + 1,
    localparam int GROUPS = PAGES / GROUP_PAGES,
    localparam int GW     = $clog2(GROUPS),
    localparam int PB     = $clog2(PAGE_HW),
    localparam int GB     = $clog2(GROUP_PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic [2:0]    reg_raddr,
    output logic [31:0]   reg_rdata,
    input  logic          fl_wr,
    input  logic [AW-1:0] fl_widx,
    input  logic [15:0]   fl_wdata,
    input  logic [AW-1:0] fl_ridx,
    output logic [15:0]   fl_rdata
);

    logic              main_open, opt_open;
    logic [9:0]        ctrl_q;
    logic [BAW-1:0]    addr_q;
    logic [GROUPS-1:0] wp_q;
    logic              pgerr_q, wperr_q, eop_q;
    logic              arr_busy, arr_finish;
    logic [15:0]       chk_data;
    op_e               start_op;
    logic [AW-1:0]     start_idx;

    logic wr_key, wr_okey, wr_stat, wr_ctrl, wr_addr, wr_wp;
    logic ctrl_ok, lock_cmd, ctrl_upd, go;
    logic want_mass, want_page, want_oer, prog_req;
    logic mass_blk, page_blk, prog_blk, prog_dirty;
    logic pgerr_set, wperr_set, eop_set;
    logic [GW-1:0] addr_grp, prog_grp;

    // Decode the register write strobe per offset.
    always_comb begin
        wr_key  = reg_wr && reg_addr == OFS_KEY;
        wr_okey = reg_wr && reg_addr == OFS_OKEY;
        wr_stat = reg_wr && reg_addr == OFS_STAT;
        wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
        wr_addr = reg_wr && reg_addr == OFS_ADDR;
        wr_wp   = reg_wr && reg_addr == OFS_WPROT;
    end

    flash_pe_keyseq u_main_keys (
        .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_data(reg_wdata),
        .enable(1'b1), .relock(lock_cmd), .open(main_open)
    );

    flash_pe_keyseq u_opt_keys (
        .clk(clk), .rst_n(rst_n), .key_wr(wr_okey), .key_data(reg_wdata),
        .enable(main_open), .relock(lock_cmd), .open(opt_open)
    );

    // Work out which action the current writes request and whether it is allowed.
    always_comb begin
        ctrl_ok   = wr_ctrl && main_open;
        lock_cmd  = ctrl_ok && reg_wdata[C_LOCK];
        ctrl_upd  = ctrl_ok && !lock_cmd && !arr_busy;
        go        = ctrl_upd && reg_wdata[C_STRT];
        want_mass = go && reg_wdata[C_MER];
        want_page = go && !reg_wdata[C_MER] && reg_wdata[C_PER];
        want_oer  = go && !reg_wdata[C_MER] && !reg_wdata[C_PER] &&
                    reg_wdata[C_OER] && reg_wdata[C_OWE] && opt_open;
        prog_req  = fl_wr && main_open && ctrl_q[C_PG] && !arr_busy && !ctrl_ok;

        addr_grp   = addr_q[1+PB+GB +: GW];
        prog_grp   = fl_widx[PB+GB +: GW];
        mass_blk   = !(&wp_q);
        page_blk   = !wp_q[addr_grp];
        prog_blk   = !wp_q[prog_grp];
        prog_dirty = chk_data != BLANK_HW;

        wperr_set = (want_mass && mass_blk) || (want_page && page_blk) ||
                    (prog_req && prog_blk);
        pgerr_set = prog_req && !prog_blk && prog_dirty;
        eop_set   = arr_finish || want_oer;

        start_op  = OP_NONE;
        start_idx = fl_widx;
        if (want_mass && !mass_blk) begin
            start_op = OP_MASS;
        end else if (want_page && !page_blk) begin
            start_op  = OP_PAGE;
            start_idx = addr_q[BAW-1:1];
        end else if (prog_req && !prog_blk && !prog_dirty) begin
            start_op = OP_PROG;
        end
    end

    flash_pe_array #(
        .WORDS(WORDS), .PAGE_HW(PAGE_HW), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .MASS_CYC(MASS_CYC)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .start_op(start_op), .start_idx(start_idx),
        .start_data(fl_wdata), .busy(arr_busy), .finish(arr_finish),
        .rd_idx(fl_ridx), .rd_data(fl_rdata), .chk_idx(fl_widx), .chk_data(chk_data)
    );

    // Hold the control, address and write-protection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            wp_q   <= '1;
        end else begin
            if (lock_cmd)      ctrl_q <= '0;
            else if (ctrl_upd) ctrl_q <= reg_wdata[9:0] & CTRL_KEEP;
            if (wr_addr && main_open && !arr_busy) addr_q <= reg_wdata[BAW-1:0];
            if (want_oer)
                wp_q <= '1;
            else if (wr_wp && opt_open && ctrl_q[C_OPG] && ctrl_q[C_OWE] && !arr_busy)
                wp_q <= wp_q & reg_wdata[GROUPS-1:0];
        end
    end

    // Status flags: a set wins over a clear by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgerr_q <= 1'b0;
            wperr_q <= 1'b0;
            eop_q   <= 1'b0;
        end else begin
            if (pgerr_set)                       pgerr_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_PGE]) pgerr_q <= 1'b0;
            if (wperr_set)                       wperr_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_WPE]) wperr_q <= 1'b0;
            if (eop_set)                         eop_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_EOP]) eop_q <= 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            OFS_STAT: begin
                reg_rdata[S_BSY] = arr_busy;
                reg_rdata[S_PGE] = pgerr_q;
                reg_rdata[S_WPE] = wperr_q;
                reg_rdata[S_EOP] = eop_q;
            end
            OFS_CTRL: begin
                reg_rdata[9:0]    = ctrl_q;
                reg_rdata[C_LOCK] = !main_open;
            end
            OFS_ADDR:  reg_rdata[BAW-1:0]    = addr_q;
            OFS_WPROT: reg_rdata[GROUPS-1:0] = wp_q;
            default:   reg_rdata = '0;
        endcase
    end

    assert_eop_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_busy) |-> eop_q);

    assert_no_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        arr_busy |-> start_op == OP_NONE);

    assert_locked_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !main_open |-> start_op == OP_NONE);

    assert_pgerr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[S_PGE] && !pgerr_set) |=> !pgerr_q);

    assert_protect_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && prog_blk) |=> (wperr_q && !arr_busy));

endmodule

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;

    localparam int PROG = 3, ERASE = 6, MASS = 10, WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = 3'd2;
    logic [31:0] reg_rdata;
    logic        fl_wr = 1'b0;
    logic [5:0]  fl_widx = '0;
    logic [15:0] fl_wdata = '0;
    logic [5:0]  fl_ridx = '0;
    logic [15:0] fl_rdata;

    int total = 0, bad = 0;
    bit cmp_on = 0;
    string phase = "R1";

    flash_pe_ctrl i_flash_pe_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .fl_wr(fl_wr), .fl_widx(fl_widx), .fl_wdata(fl_wdata),
        .fl_ridx(fl_ridx), .fl_rdata(fl_rdata)
    );

    always #10 clk = ~clk;

    // Behavioural reference model.
    int mk, mo, maddr, mbusy, mcnt, mop, midx;
    logic [31:0] mctrl;
    logic [3:0]  mwp;
    logic [15:0] mdat;
    logic        mpg, mwe, meop;
    logic [15:0] mem [WORDS];
    bit t_open, t_oopen, t_cok, t_lock, t_upd, t_go, t_mass, t_page, t_oer, t_prog;
    int t_pg, t_ag;

    always @(posedge clk) begin
        if (!rst_n) begin
            mk = 0; mo = 0; maddr = 0; mbusy = 0; mcnt = 0; mop = 0; midx = 0;
            mctrl = 0; mwp = 4'hF; mdat = 0; mpg = 0; mwe = 0; meop = 0;
            for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
        end else begin
            t_open  = (mk == 2);
            t_oopen = (mo == 2);
            t_cok   = reg_wr && reg_addr == 3 && t_open;
            t_lock  = t_cok && reg_wdata[7];
            t_upd   = t_cok && !t_lock && mbusy == 0;
            t_go    = t_upd && reg_wdata[6];
            t_mass  = t_go && reg_wdata[2];
            t_page  = t_go && !reg_wdata[2] && reg_wdata[1];
            t_oer   = t_go && !reg_wdata[2] && !reg_wdata[1] && reg_wdata[5] && reg_wdata[9] && t_oopen;
            t_prog  = fl_wr && t_open && mctrl[0] && mbusy == 0 && !t_cok;
            t_pg    = int'(fl_widx) / 16;
            t_ag    = maddr / 32;
            if ((t_mass && mwp != 4'hF) || (t_page && !mwp[t_ag]) || (t_prog && !mwp[t_pg])) mwe = 1;
            else if (reg_wr && reg_addr == 2 && reg_wdata[4]) mwe = 0;
            if (t_prog && mwp[t_pg] && mem[fl_widx] != 16'hFFFF) mpg = 1;
            else if (reg_wr && reg_addr == 2 && reg_wdata[2]) mpg = 0;
            if ((mbusy != 0 && mcnt == 1) || t_oer) meop = 1;
            else if (reg_wr && reg_addr == 2 && reg_wdata[5]) meop = 0;
            if (t_oer) mwp = 4'hF;
            else if (reg_wr && reg_addr == 5 && t_oopen && mctrl[4] && mctrl[9] && mbusy == 0)
                mwp = mwp & reg_wdata[3:0];
            if (reg_wr && reg_addr == 4 && t_open && mbusy == 0) maddr = int'(reg_wdata[6:0]);
            if (t_lock) mctrl = 0;
            else if (t_upd) mctrl = reg_wdata & 32'h237;
            if (t_lock && mk != 3) mk = 0;
            else if (reg_wr && reg_addr == 0) begin
                if (mk == 0) mk = (reg_wdata == 32'h45670123) ? 1 : 3;
                else if (mk == 1) mk = (reg_wdata == 32'hCDEF89AB) ? 2 : 3;
            end
            if (t_lock && mo != 3) mo = 0;
            else if (reg_wr && reg_addr == 1 && t_open) begin
                if (mo == 0) mo = (reg_wdata == 32'h45670123) ? 1 : 3;
                else if (mo == 1) mo = (reg_wdata == 32'hCDEF89AB) ? 2 : 3;
            end
            if (mbusy != 0) begin
                if (mcnt == 1) begin
                    mbusy = 0;
                    if (mop == 1) mem[midx] = mem[midx] & mdat;
                    else if (mop == 2) begin
                        for (int i = 0; i < WORDS; i++) if (i / 4 == midx / 4) mem[i] = 16'hFFFF;
                    end else for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
                end else mcnt = mcnt - 1;
            end else if (t_mass && mwp == 4'hF) begin
                mbusy = 1; mop = 3; mcnt = MASS;
            end else if (t_page && mwp[t_ag]) begin
                mbusy = 1; mop = 2; mcnt = ERASE; midx = maddr / 2;
            end else if (t_prog && mwp[t_pg] && mem[fl_widx] == 16'hFFFF) begin
                mbusy = 1; mop = 1; mcnt = PROG; midx = int'(fl_widx); mdat = fl_wdata;
            end
        end
    end

    function automatic logic [31:0] mread(logic [2:0] a);
        case (a)
            3'd2: return {26'd0, meop, mwe, 1'b0, mpg, 1'b0, mbusy[0]};
            3'd3: return mctrl | ((mk != 2) ? 32'h80 : 32'h0);
            3'd4: return 32'(maddr);
            3'd5: return {28'd0, mwp};
            default: return 32'd0;
        endcase
    endfunction

    // Compare every cycle against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            total++;
            if (reg_rdata !== mread(reg_raddr) || fl_rdata !== mem[fl_ridx]) begin
                bad++;
                $display("FAIL %s cycle compare: reg=%h exp %h flash=%h exp %h", phase,
                         reg_rdata, mread(reg_raddr), fl_rdata, mem[fl_ridx]);
            end
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 0;
    endtask

    task automatic wfl(logic [5:0] i, logic [15:0] d);
        fl_wr = 1; fl_widx = i; fl_wdata = d; cyc(); fl_wr = 0;
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic creg(string req, logic [2:0] a, logic [31:0] exp);
        reg_raddr = a; #1; chk(req, reg_rdata, exp);
    endtask

    task automatic cfl(string req, logic [5:0] i, logic [15:0] exp);
        fl_ridx = i; #1; chk(req, {16'd0, fl_rdata}, {16'd0, exp});
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(2); rst_n = 1;
    endtask

    task automatic unlock();
        wreg(3'd0, 32'h45670123); wreg(3'd0, 32'hCDEF89AB);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(); do_reset(); cmp_on = 1;
        phase = "R1";
        creg("R1 status", 3'd2, 32'h0);
        creg("R1 control", 3'd3, 32'h80);
        creg("R1 address", 3'd4, 32'h0);
        creg("R1 wprot", 3'd5, 32'hF);
        cfl("R1 array", 6'd0, 16'hFFFF);

        phase = "R2";
        wreg(3'd3, 32'h1);
        creg("R2 locked control write ignored", 3'd3, 32'h80);
        unlock();
        creg("R2 unlocked", 3'd3, 32'h0);

        phase = "R5";
        wreg(3'd3, 32'h1);
        wfl(6'd1, 16'h1234);
        creg("R5 busy after start", 3'd2, 32'h1);
        cyc(2);
        creg("R5 still busy", 3'd2, 32'h1);
        cfl("R5 array not yet written", 6'd1, 16'hFFFF);
        cyc();
        creg("R5 eop on busy fall", 3'd2, 32'h20);
        cfl("R5 array written", 6'd1, 16'h1234);

        phase = "R6";
        wfl(6'd1, 16'h0000);
        creg("R6 program error, no busy", 3'd2, 32'h24);
        cfl("R6 array unchanged", 6'd1, 16'h1234);

        phase = "R10";
        wreg(3'd2, 32'h0);
        creg("R10 zero write no effect", 3'd2, 32'h24);
        wreg(3'd2, 32'h4);
        creg("R10 clear prog error", 3'd2, 32'h20);
        wreg(3'd2, 32'h20);
        creg("R10 clear eop", 3'd2, 32'h0);

        phase = "R13";
        wfl(6'd2, 16'hAAAA);
        wreg(3'd4, 32'h10);
        wfl(6'd3, 16'h5555);
        cyc(2);
        creg("R13 address write ignored", 3'd4, 32'h0);
        cfl("R13 flash write ignored", 6'd3, 16'hFFFF);
        cfl("R13 first program done", 6'd2, 16'hAAAA);
        wreg(3'd2, 32'h20);

        phase = "R7";
        wfl(6'd4, 16'h0F0F);
        cyc(PROG);
        wreg(3'd3, 32'h2);
        wreg(3'd4, 32'h2);
        wreg(3'd3, 32'h42);
        cyc(ERASE - 1);
        creg("R7 busy during erase", 3'd2, 32'h21);
        cyc();
        creg("R7 erase done", 3'd2, 32'h20);
        cfl("R7 page cleared", 6'd1, 16'hFFFF);
        cfl("R7 page cleared 2", 6'd2, 16'hFFFF);
        cfl("R7 other page kept", 6'd4, 16'h0F0F);
        wreg(3'd2, 32'h20);

        phase = "R8";
        wreg(3'd3, 32'h46);
        cyc(MASS - 1);
        creg("R8 busy during mass erase", 3'd2, 32'h1);
        cfl("R8 not yet erased", 6'd4, 16'h0F0F);
        cyc();
        creg("R8 mass done", 3'd2, 32'h20);
        cfl("R8 all erased", 6'd4, 16'hFFFF);
        wreg(3'd2, 32'h20);

        phase = "R11";
        wreg(3'd3, 32'h210);
        wreg(3'd5, 32'h0);
        creg("R11 wprot guarded without option keys", 3'd5, 32'hF);
        wreg(3'd1, 32'h45670123); wreg(3'd1, 32'hCDEF89AB);
        wreg(3'd5, 32'hE);
        creg("R11 wprot written", 3'd5, 32'hE);
        wreg(3'd5, 32'hD);
        creg("R11 wprot ANDed", 3'd5, 32'hC);

        phase = "R9";
        wreg(3'd3, 32'h1);
        wfl(6'd0, 16'h1111);
        creg("R9 protected program", 3'd2, 32'h10);
        cfl("R9 array unchanged", 6'd0, 16'hFFFF);
        wfl(6'd32, 16'hBEEF);
        cyc(PROG);
        creg("R9 unprotected group programs", 3'd2, 32'h30);
        cfl("R9 group 2 written", 6'd32, 16'hBEEF);
        wreg(3'd2, 32'h30);
        wreg(3'd3, 32'h2); wreg(3'd4, 32'h4); wreg(3'd3, 32'h42);
        creg("R9 protected page erase", 3'd2, 32'h10);
        wreg(3'd3, 32'h46);
        creg("R9 mass erase refused", 3'd2, 32'h10);
        cyc(MASS);
        cfl("R9 array kept", 6'd32, 16'hBEEF);
        wreg(3'd2, 32'h10);

        phase = "R12";
        wreg(3'd3, 32'h220);
        wreg(3'd3, 32'h260);
        creg("R12 wprot restored", 3'd5, 32'hF);
        creg("R12 eop", 3'd2, 32'h20);
        wreg(3'd2, 32'h20);

        phase = "R4";
        wreg(3'd3, 32'h1);
        wreg(3'd3, 32'h80);
        creg("R4 relocked, modes cleared", 3'd3, 32'h80);
        wreg(3'd3, 32'h1);
        creg("R4 control ignored", 3'd3, 32'h80);
        wfl(6'd40, 16'h2222);
        cyc(PROG);
        cfl("R4 flash write ignored", 6'd40, 16'hFFFF);
        creg("R4 no busy", 3'd2, 32'h0);
        unlock();
        creg("R4 fresh unlock", 3'd3, 32'h0);

        phase = "R3";
        do_reset();
        wreg(3'd0, 32'hCDEF89AB);
        unlock();
        creg("R3 out of order stays locked", 3'd3, 32'h80);
        do_reset();
        wreg(3'd0, 32'h45670123);
        wreg(3'd0, 32'h12345678);
        unlock();
        creg("R3 wrong key stays locked", 3'd3, 32'h80);
        do_reset();
        unlock();
        creg("R3 reset frees the sequence", 3'd3, 32'h0);
        cyc(2);
        summary();
    end

endmodule